// File: doc/BRIEF.md
# Reloadable Up/Down Event Counter

This block is a 16-bit event counter for a timer subsystem. While enabled it advances one step for each qualifying event, either an edge on an external count pin or an overflow pulse from one of three neighbouring timers. Each step moves the count up or down. The direction comes from a software flag or from the level on a direction pin. A separate input switches the counter to a two-phase (quadrature) encoder input. In that mode it decodes either one count per cycle of phase A or one count per edge of either phase.

When the count passes its top value going up, or its bottom value going down, the block wraps. In reload operation it then continues from a stored reload value. In free-run operation it continues from the opposite end of the range. Every wrap produces a one-cycle interrupt request and can toggle a pulse output pin.

Software writes the counter register through a simple write strobe. When the counter is stopped, the write sets both the reload value and the count. When it is running, the write sets only the reload value, and the count picks it up at the next wrap. The live count can be read on `rd_data` at any time. Pin inputs pass through two-stage synchronisers before edge detection.

Top module: `evcnt_top`

## Requirements
- R1: After reset, `rd_data` is 0, `irq` is 0, `pulse_out` is 0 and `pulse_oe` is 0, and the mode register holds 00h, so the block does not count.
- R2: The count changes on an event only while `start` is 1 and mode bits {5,1,0} equal 3'b001. Mode bits [1:0] = 00, or bit 5 = 1, or `start` = 0, leaves `rd_data` unchanged.
- R3: With `quad_en` = 0, `src_sel` = 0 counts edges of `ext_in`. `src_sel` = 1, 2 or 3 counts the single-cycle pulses on `sib_ovf[0]`, `sib_ovf[1]` or `sib_ovf[2]` respectively, and pulses on the other bits are ignored.
- R4: When `src_sel` = 0, mode bit 3 = 1 counts rising edges of `ext_in` and mode bit 3 = 0 counts falling edges. The opposite edge is ignored.
- R5: Outside quadrature mode, mode bit 4 = 0 takes the direction from `up_flag`, and mode bit 4 = 1 takes it from the level of `dir_pin`. In both cases 1 means up and 0 means down.
- R6: With mode bit 6 = 0 (reload), a step up from FFFFh or a step down from 0000h loads the reload value into the count.
- R7: With mode bit 6 = 1 (free-run), a step up from FFFFh gives 0000h and a step down from 0000h gives FFFFh. The reload value is not used.
- R8: A write on `wr_en` while not counting sets both the count and the reload value to `wr_data`. A write while counting leaves the count unchanged and sets only the reload value, which the count takes at its next reload.
- R9: Each wrap raises `irq` for exactly one clock cycle, in the cycle after the step.
- R10: With mode bit 2 = 1, `pulse_out` inverts on every wrap. With mode bit 2 = 0, `pulse_out` is held at 0. `pulse_oe` equals mode bit 2 AND NOT mode bit 4.
- R11: With `quad_en` = 1 and mode bit 7 = 0, the counter steps on each rising edge of `ext_in` (phase A). It counts up when `ext_b` (phase B) is low and down when it is high.
- R12: With `quad_en` = 1 and mode bit 7 = 1, the counter steps on every single-phase change of {`ext_in`,`ext_b`}. The sequence 00,10,11,01 counts up and the reverse sequence counts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wd | input | 8 | Mode register write data |
| start | input | 1 | Count enable flag |
| src_sel | input | 2 | Count source select |
| sib_ovf | input | 3 | Overflow pulses from neighbouring timers |
| ext_in | input | 1 | External count pin / quadrature phase A |
| ext_b | input | 1 | Quadrature phase B |
| quad_en | input | 1 | Two-phase input mode enable |
| up_flag | input | 1 | Software direction flag, 1 = up |
| dir_pin | input | 1 | Direction pin level, 1 = up |
| wr_en | input | 1 | Counter register write strobe |
| wr_data | input | 16 | Counter register write data |
| rd_data | output | 16 | Live count value |
| irq | output | 1 | Wrap interrupt request pulse |
| pulse_out | output | 1 | Wrap-toggled output level |
| pulse_oe | output | 1 | Output drive enable for the pulse pin |

## Verification
The main counting path is driven by neighbour pulses on the selected and on unselected lines, which shows whether the source mux picks the right bit. Single rising and falling halves of an external pulse are applied and the count is checked after each half, which shows which edge the polarity bit selects. Runs that end at FFFFh and at 0000h, in reload and in free-run, separate reloading from wrapping. A write made while running, followed by a count to underflow, shows that the new value is deferred to the reload. Quadrature sequences in both orders, in normal and multiply-by-4 decoding, separate counts per cycle from counts per edge and show the direction taken from phase order.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  typedef struct packed {
    logic       quad_x4;    // bit 7
    logic       free_run;   // bit 6
    logic       rsv0;       // bit 5, must be 0
    logic       dir_pin_en; // bit 4
    logic       rise_edge;  // bit 3
    logic       pulse_en;   // bit 2
    logic [1:0] op;         // bits 1:0
  } mode_t;

  localparam logic [1:0] OP_EVENT = 2'b01;

endpackage

// File: rtl/evcnt_sync.sv
module evcnt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/evcnt_src.sv
module evcnt_src #(
  parameter int NSIB = 3,
  localparam int SELW = $clog2(NSIB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin_a,
  input  logic            pin_b,
  input  logic            pin_dir,
  input  logic [NSIB-1:0] sib_ovf,
  input  logic [SELW-1:0] src_sel,
  input  logic            quad_en,
  input  logic            quad_x4,
  input  logic            rise_edge,
  input  logic            dir_pin_en,
  input  logic            up_flag,
  output logic            step,
  output logic            up
);

  logic a_prev_q, b_prev_q;
  logic a_prev_d, b_prev_d;
  logic a_rise, a_fall, b_chg, a_chg;
  logic pin_step;
  logic [NSIB-1:0] sib_hit;
  logic sib_step;
  logic single_step, single_up;
  logic quad_step, quad_up;

  // previous-sample registers for edge detection
  assign a_prev_d = pin_a;
  assign b_prev_d = pin_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_prev_d;
      b_prev_q <= b_prev_d;
    end
  end

  assign a_rise = pin_a & ~a_prev_q;
  assign a_fall = ~pin_a & a_prev_q;
  assign a_chg  = pin_a ^ a_prev_q;
  assign b_chg  = pin_b ^ b_prev_q;

  assign pin_step = rise_edge ? a_rise : a_fall;

  // neighbour overflow select: code g+1 picks line g
  genvar g;
  generate
    for (g = 0; g < NSIB; g++) begin : g_sib
      assign sib_hit[g] = sib_ovf[g] & (src_sel == SELW'(g + 1));
    end
  endgenerate
  assign sib_step = |sib_hit;

  always_comb begin
    single_step = (src_sel == '0) ? pin_step : sib_step;
    single_up   = dir_pin_en ? pin_dir : up_flag;
  end

  // two-phase decoding
  always_comb begin
    if (quad_x4) begin
      quad_step = a_chg ^ b_chg;            // exactly one phase moved
      quad_up   = (a_prev_q == pin_b);      // 00->10->11->01 is up
    end else begin
      quad_step = a_rise;
      quad_up   = ~pin_b;
    end
  end

  assign step = quad_en ? quad_step : single_step;
  assign up   = quad_en ? quad_up   : single_up;

endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         up,
  input  logic         free_run,
  input  logic         pulse_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         irq,
  output logic         pulse_out
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_MIN = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] rld_q, rld_d;
  logic         irq_q, irq_d;
  logic         pls_q, pls_d;
  logic         wrap;
  logic         adv;

  assign adv = run & step;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    wrap  = 1'b0;
    if (adv) begin
      if (up) begin
        if (cnt_q == CNT_MAX) begin
          wrap  = 1'b1;
          cnt_d = free_run ? CNT_MIN : rld_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == CNT_MIN) begin
          wrap  = 1'b1;
          cnt_d = free_run ? CNT_MAX : rld_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
    if (wr_en) begin
      rld_d = wr_data;
      if (!run) cnt_d = wr_data;
    end
  end

  always_comb begin
    irq_d = wrap;
    if (!pulse_en)  pls_d = 1'b0;
    else if (wrap)  pls_d = ~pls_q;
    else            pls_d = pls_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      irq_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      irq_q <= irq_d;
      pls_q <= pls_d;
    end
  end

  assign cnt       = cnt_q;
  assign irq       = irq_q;
  assign pulse_out = pls_q;

endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
  import evcnt_pkg::*;
#(
  parameter int W    = 16,
  parameter int NSIB = 3,
  localparam int SELW = $clog2(NSIB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_we,
  input  logic [7:0]      mode_wd,
  input  logic            start,
  input  logic [SELW-1:0] src_sel,
  input  logic [NSIB-1:0] sib_ovf,
  input  logic            ext_in,
  input  logic            ext_b,
  input  logic            quad_en,
  input  logic            up_flag,
  input  logic            dir_pin,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    rd_data,
  output logic            irq,
  output logic            pulse_out,
  output logic            pulse_oe
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // mode register
  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = mode_t'(mode_wd);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= mode_t'(8'h00);
    else            mode_q <= mode_d;
  end

  logic run;
  logic pulse_en, free_run;
  assign run      = start & (mode_q.op == OP_EVENT) & ~mode_q.rsv0;
  assign pulse_en = mode_q.pulse_en;
  assign free_run = mode_q.free_run;
  assign pulse_oe = mode_q.pulse_en & ~mode_q.dir_pin_en;

  // pin synchronisers
  logic [2:0] pins_raw, pins_s;
  assign pins_raw = {dir_pin, ext_b, ext_in};

  evcnt_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic step, up;

  evcnt_src #(.NSIB(NSIB)) u_src (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_a      (pins_s[0]),
    .pin_b      (pins_s[1]),
    .pin_dir    (pins_s[2]),
    .sib_ovf    (sib_ovf),
    .src_sel    (src_sel),
    .quad_en    (quad_en),
    .quad_x4    (mode_q.quad_x4),
    .rise_edge  (mode_q.rise_edge),
    .dir_pin_en (mode_q.dir_pin_en),
    .up_flag    (up_flag),
    .step       (step),
    .up         (up)
  );

  evcnt_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .step      (step),
    .up        (up),
    .free_run  (free_run),
    .pulse_en  (pulse_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cnt       (rd_data),
    .irq       (irq),
    .pulse_out (pulse_out)
  );

endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         wr_en,
  input logic [W-1:0] rd_data,
  input logic         irq,
  input logic         pulse_out,
  input logic         pulse_en,
  input logic         free_run
);

  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] BOT = '0;

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_en) |=> $stable(rd_data));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_from_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(rd_data) == TOP || $past(rd_data) == BOT));

  p_free_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(free_run)) |-> (rd_data == TOP || rd_data == BOT));

  p_pulse_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(pulse_en)) |-> (pulse_out != $past(pulse_out)));

  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_en |=> !pulse_out);

endmodule

bind evcnt_top evcnt_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .wr_en     (wr_en),
  .rd_data   (rd_data),
  .irq       (irq),
  .pulse_out (pulse_out),
  .pulse_en  (pulse_en),
  .free_run  (free_run)
);

// File: tb/evcnt_top_tb.sv
module evcnt_top_tb;

  localparam logic [7:0] M_EV   = 8'h01;
  localparam logic [7:0] M_PO   = 8'h04;
  localparam logic [7:0] M_RISE = 8'h08;
  localparam logic [7:0] M_DPIN = 8'h10;
  localparam logic [7:0] M_RSV  = 8'h20;
  localparam logic [7:0] M_FREE = 8'h40;
  localparam logic [7:0] M_X4   = 8'h80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we;
  logic [7:0]  mode_wd;
  logic        start;
  logic [1:0]  src_sel;
  logic [2:0]  sib_ovf;
  logic        ext_in, ext_b, quad_en, up_flag, dir_pin;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        irq, pulse_out, pulse_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  evcnt_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wd(mode_wd),
    .start(start), .src_sel(src_sel), .sib_ovf(sib_ovf), .ext_in(ext_in),
    .ext_b(ext_b), .quad_en(quad_en), .up_flag(up_flag), .dir_pin(dir_pin),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_cnt(input string tag, input int exp);
    check(rd_data == 16'(exp), tag, int'(rd_data), exp);
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wd = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic write_cnt(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // one-cycle pulse on neighbour lines; returns irq level in the following cycle
  task automatic sib_pulse(input logic [2:0] lines, output logic irq_seen);
    @(negedge clk); sib_ovf = lines;
    @(negedge clk); sib_ovf = 3'b000; irq_seen = irq;
  endtask

  task automatic set_pins(input logic a, input logic b);
    @(negedge clk); ext_in = a; ext_b = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_cnt("R1 count after reset", 0);
    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    check(pulse_out == 1'b0, "R1 pulse_out after reset", int'(pulse_out), 0);
    check(pulse_oe == 1'b0, "R1 pulse_oe after reset", int'(pulse_oe), 0);
    start = 1'b1; src_sel = 2'd1;
    sib_pulse(3'b001, irq);
    repeat (2) @(negedge clk);
    chk_cnt("R1 idle mode does not count", 0);
    start = 1'b0;
  endtask

  task automatic t_enable;
    logic s;
    set_mode(M_EV); up_flag = 1'b1; src_sel = 2'd1;
    write_cnt(16'h0100);
    chk_cnt("R8 write while stopped", 16'h0100);
    sib_pulse(3'b001, s);
    chk_cnt("R2 no count with start low", 16'h0100);
    start = 1'b1;
    set_mode(8'h00);
    sib_pulse(3'b001, s);
    chk_cnt("R2 no count with op field 00", 16'h0100);
    set_mode(M_EV | M_RSV);
    sib_pulse(3'b001, s);
    chk_cnt("R2 no count with bit5 set", 16'h0100);
    set_mode(M_EV);
    sib_pulse(3'b001, s);
    chk_cnt("R2 counts when enabled", 16'h0101);
    start = 1'b0;
  endtask

  task automatic t_source;
    logic s;
    set_mode(M_EV); up_flag = 1'b1;
    write_cnt(16'h0000);
    start = 1'b1; src_sel = 2'd2;
    sib_pulse(3'b010, s); sib_pulse(3'b010, s); sib_pulse(3'b010, s);
    sib_pulse(3'b001, s); sib_pulse(3'b100, s);
    chk_cnt("R3 src 2 counts line 1 only", 3);
    src_sel = 2'd3;
    sib_pulse(3'b100, s); sib_pulse(3'b011, s);
    chk_cnt("R3 src 3 counts line 2 only", 4);
    src_sel = 2'd0;
    sib_pulse(3'b111, s);
    chk_cnt("R3 src 0 ignores neighbour lines", 4);
    start = 1'b0;
  endtask

  task automatic t_edge;
    start = 1'b0;
    set_mode(M_EV | M_RISE); up_flag = 1'b1; src_sel = 2'd0;
    write_cnt(16'd100);
    start = 1'b1;
    set_pins(1'b1, 1'b0);
    chk_cnt("R4 rising edge counted", 101);
    set_pins(1'b0, 1'b0);
    chk_cnt("R4 falling edge ignored in rising mode", 101);
    set_mode(M_EV);
    set_pins(1'b1, 1'b0);
    chk_cnt("R4 rising edge ignored in falling mode", 101);
    set_pins(1'b0, 1'b0);
    chk_cnt("R4 falling edge counted", 102);
    start = 1'b0;
  endtask

  task automatic t_dir;
    logic s;
    set_mode(M_EV); src_sel = 2'd1; up_flag = 1'b0;
    write_cnt(16'd10);
    start = 1'b1;
    sib_pulse(3'b001, s);
    chk_cnt("R5 flag down", 9);
    set_mode(M_EV | M_DPIN);
    @(negedge clk); dir_pin = 1'b1; repeat (4) @(negedge clk);
    sib_pulse(3'b001, s);
    chk_cnt("R5 pin high counts up despite flag", 10);
    @(negedge clk); dir_pin = 1'b0; up_flag = 1'b1; repeat (4) @(negedge clk);
    sib_pulse(3'b001, s);
    chk_cnt("R5 pin low counts down despite flag", 9);
    start = 1'b0;
  endtask

  task automatic t_reload;
    logic s;
    set_mode(M_EV); src_sel = 2'd1; up_flag = 1'b1;
    write_cnt(16'hFFFD);
    start = 1'b1;
    sib_pulse(3'b001, s); sib_pulse(3'b001, s);
    chk_cnt("R6 up to top", 16'hFFFF);
    check(s == 1'b0, "R9 no irq before wrap", int'(s), 0);
    sib_pulse(3'b001, s);
    chk_cnt("R6 overflow reloads", 16'hFFFD);
    check(s == 1'b1, "R9 irq on overflow", int'(s), 1);
    @(negedge clk);
    check(irq == 1'b0, "R9 irq lasts one cycle", int'(irq), 0);
    start = 1'b0; up_flag = 1'b0;
    write_cnt(16'h0002);
    start = 1'b1;
    sib_pulse(3'b001, s); sib_pulse(3'b001, s);
    chk_cnt("R6 down to zero", 0);
    write_cnt(16'h0005);
    chk_cnt("R8 running write leaves count", 0);
    sib_pulse(3'b001, s);
    chk_cnt("R8 new reload taken at underflow", 5);
    check(s == 1'b1, "R9 irq on underflow", int'(s), 1);
    start = 1'b0;
  endtask

  task automatic t_free;
    logic s;
    set_mode(M_EV | M_FREE); src_sel = 2'd1; up_flag = 1'b1;
    write_cnt(16'h1234);
    write_cnt(16'hFFFF);
    start = 1'b1;
    write_cnt(16'h1234);
    sib_pulse(3'b001, s);
    chk_cnt("R7 free-run overflow to zero", 0);
    check(s == 1'b1, "R9 irq on free-run wrap", int'(s), 1);
    up_flag = 1'b0;
    sib_pulse(3'b001, s);
    chk_cnt("R7 free-run underflow to top", 16'hFFFF);
    start = 1'b0;
  endtask

  task automatic t_pulse;
    logic s;
    set_mode(M_EV | M_PO | M_FREE); src_sel = 2'd1; up_flag = 1'b1;
    @(negedge clk);
    check(pulse_oe == 1'b1, "R10 output enabled", int'(pulse_oe), 1);
    write_cnt(16'hFFFF);
    start = 1'b1;
    sib_pulse(3'b001, s);
    check(pulse_out == 1'b1, "R10 first wrap toggles", int'(pulse_out), 1);
    start = 1'b0; write_cnt(16'hFFFF); start = 1'b1;
    sib_pulse(3'b001, s);
    check(pulse_out == 1'b0, "R10 second wrap toggles back", int'(pulse_out), 0);
    start = 1'b0; write_cnt(16'hFFFF); start = 1'b1;
    sib_pulse(3'b001, s);
    check(pulse_out == 1'b1, "R10 third wrap", int'(pulse_out), 1);
    set_mode(M_EV | M_FREE);
    @(negedge clk);
    check(pulse_out == 1'b0, "R10 disabled holds low", int'(pulse_out), 0);
    check(pulse_oe == 1'b0, "R10 oe off when disabled", int'(pulse_oe), 0);
    set_mode(M_EV | M_PO | M_DPIN);
    @(negedge clk);
    check(pulse_oe == 1'b0, "R10 oe off when pin is direction input", int'(pulse_oe), 0);
    start = 1'b0;
  endtask

  task automatic t_quad_normal;
    set_mode(M_EV);
    write_cnt(16'd50);
    quad_en = 1'b1; start = 1'b1;
    set_pins(1'b1, 1'b0);
    chk_cnt("R11 A rise with B low counts up", 51);
    set_pins(1'b0, 1'b0);
    chk_cnt("R11 A fall ignored", 51);
    set_pins(1'b0, 1'b1);
    chk_cnt("R11 B edge ignored", 51);
    set_pins(1'b1, 1'b1);
    chk_cnt("R11 A rise with B high counts down", 50);
    set_pins(1'b0, 1'b1);
    set_pins(1'b0, 1'b0);
    chk_cnt("R11 return to rest", 50);
    start = 1'b0;
  endtask

  task automatic t_quad_x4;
    set_mode(M_EV | M_X4);
    write_cnt(16'd50);
    start = 1'b1;
    set_pins(1'b1, 1'b0);
    chk_cnt("R12 first edge up", 51);
    set_pins(1'b1, 1'b1); set_pins(1'b0, 1'b1); set_pins(1'b0, 1'b0);
    chk_cnt("R12 forward cycle counts four", 54);
    set_pins(1'b0, 1'b1);
    chk_cnt("R12 reverse edge down", 53);
    set_pins(1'b1, 1'b1); set_pins(1'b1, 1'b0); set_pins(1'b0, 1'b0);
    chk_cnt("R12 reverse cycle counts four down", 50);
    start = 1'b0; quad_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode_we = 1'b0; mode_wd = 8'h00; start = 1'b0;
    src_sel = 2'd0; sib_ovf = 3'b000; ext_in = 1'b0; ext_b = 1'b0;
    quad_en = 1'b0; up_flag = 1'b1; dir_pin = 1'b0; wr_en = 1'b0; wr_data = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_source();
    t_edge();
    t_dir();
    t_reload();
    t_free();
    t_pulse();
    t_quad_normal();
    t_quad_x4();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule